// File: doc/BRIEF.md
# Serial EEPROM Transaction Sequencer

This block is a serial-peripheral-bus master that runs whole EEPROM operations from one request. A request carries an operation, an 8-bit byte address, a byte count of 1 to 8 and up to eight data bytes. The block builds each command frame, drives the serial clock, chip select and the output data line, samples the input data line, and ends each operation with a one-cycle done pulse, a 2-bit result code and, for reads, the received bytes.

A write request runs as a chain of frames. The block first sends the write-enable command in its own frame. It then reads the status register and checks the write-enabled bit. Next it sends the program command with the address and the data. Last, it polls status until the busy bit reads zero or the poll budget runs out. A write whose bytes would span two 8-byte aligned pages is refused before any bus traffic. A read sends the read command and the address, then collects the requested bytes. A write-disable request sends one single-byte frame.

Top module: `spi_eeprom_seq`

## Requirements
- R1: A request is taken only in a cycle where req_valid and req_ready are both high. req_ready is high only while no operation is running, and req_valid pulses while busy have no effect on the frames sent or on the result.
- R2: Every accepted request ends with done high for exactly one cycle, with req_ready high in that cycle. result then holds 0 (ok), 1 (invalid request), 2 (write not enabled) or 3 (device stayed busy).
- R3: The request ends with result 1 and no chip-select activity, with done in the cycle after acceptance, when any of these holds: req_len is 0 or above 8; req_op is 3; or a write (req_op 1) has its first byte (req_addr) and last byte (req_addr+req_len-1) in different 8-byte aligned pages.
- R4: A write (req_op 1) starts with a one-byte frame 0x06. It follows with a two-byte frame of 0x05 and a 0x00 dummy, and the status is the byte received in the second byte time.
- R5: If bit 1 of that status is 0, the write ends with result 2 and no further frame.
- R6: Otherwise the next frame is 0x02, the address, then req_len data bytes, with data byte i taken from req_wdata[8i+7:8i].
- R7: After the data frame the block sends two-byte status frames (0x05, 0x00). It ends with result 0 at the first status whose bit 0 is 0, and with result 3 after POLLS status frames that all show bit 0 set.
- R8: A read (req_op 0) sends one frame of 0x03, the address and req_len dummy bytes. It discards the first two received bytes, places received byte i in rdata[8i+7:8i], clears the unused rdata bytes and ends with result 0.
- R9: A write-disable (req_op 2) sends the single-byte frame 0x04 and ends with result 0.
- R10: The serial clock idles low outside frames and its high and low phases each last ceil(CLK_HZ/(2*SCK_HZ)) system cycles. Bytes are sent most significant bit first. The output data line changes only while the serial clock is low, and input data is sampled on its rising edge.
- R11: Chip select goes low at least one serial-clock period before the first rising edge and stays low at least one period after the last falling edge. Between frames it stays high at least one period.
- R12: After reset, chip select is high, the serial clock low, req_ready high and done low.
- R13: Consecutive status polls are separated by a chip-select-high time of at least GAP_US microseconds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe |
| req_op | input | 2 | 0 read, 1 write, 2 write-disable, 3 reserved |
| req_addr | input | 8 | EEPROM byte address |
| req_len | input | 4 | Byte count, 1 to 8 |
| req_wdata | input | 64 | Write bytes, byte 0 in the low bits |
| req_ready | output | 1 | High while idle and able to take a request |
| done | output | 1 | One-cycle completion pulse |
| result | output | 2 | Completion code, valid with done |
| rdata | output | 64 | Read bytes, byte 0 in the low bits |
| sck | output | 1 | Serial clock |
| cs_n | output | 1 | Chip select, active low |
| mosi | output | 1 | Serial data to the device |
| miso | input | 1 | Serial data from the device |

## Verification
A wrong frame selection in the controller appears at once on the serial line as a wrong command byte or byte count. The device model logs every frame, so it is caught in the frame where it happens. A status byte taken from the wrong byte time or bit turns into the wrong result code at the end of the operation: a write passes although it should fail, or fails although it should pass. A bad poll counter or gap counter shows up as a wrong number of status frames or a too-short chip-select-high time between polls.

// File: rtl/spi_eeprom_pkg.sv
`timescale 1ns/1ps
package spi_eeprom_pkg;
    typedef enum logic [1:0] {OP_READ = 2'd0, OP_WRITE = 2'd1, OP_WRDIS = 2'd2, OP_RSVD = 2'd3} op_e;
    typedef enum logic [1:0] {RES_OK = 2'd0, RES_INVAL = 2'd1, RES_PERM = 2'd2, RES_IO = 2'd3} res_e;
    typedef enum logic [2:0] {E_IDLE, E_SETUP, E_LO, E_HI, E_HOLD, E_GAP} eng_st_e;
    typedef enum logic [1:0] {C_IDLE, C_LAUNCH, C_WAIT, C_DELAY} ctl_st_e;
    typedef enum logic [2:0] {F_WREN, F_CHK, F_WRITE, F_POLL, F_READ, F_WRDI} frm_e;

    localparam logic [7:0] CMD_WREN  = 8'h06;
    localparam logic [7:0] CMD_WRDI  = 8'h04;
    localparam logic [7:0] CMD_RDSR  = 8'h05;
    localparam logic [7:0] CMD_PROG  = 8'h02;
    localparam logic [7:0] CMD_READ  = 8'h03;
    localparam int         ST_BUSY   = 0;
    localparam int         ST_WEN    = 1;
endpackage

// File: rtl/eeprom_req_check.sv
`timescale 1ns/1ps
module eeprom_req_check
    import spi_eeprom_pkg::*;
#(
    parameter int MAXB = 8,
    parameter int PAGE = 8,
    parameter int LW   = $clog2(MAXB + 1)
) (
    input  logic [1:0]    op,
    input  logic [7:0]    addr,
    input  logic [LW-1:0] len,
    output logic          bad
);
    localparam int PGB = $clog2(PAGE);

    logic [7:0] last_byte;

    always_comb begin
        last_byte = addr + (8'(len) - 8'd1);
        bad = (len == '0) || (len > LW'(MAXB)) || (op_e'(op) == OP_RSVD) ||
              ((op_e'(op) == OP_WRITE) && (last_byte[7:PGB] != addr[7:PGB]));
    end
endmodule

// File: rtl/spi_frame_engine.sv
`timescale 1ns/1ps
module spi_frame_engine
    import spi_eeprom_pkg::*;
#(
    parameter int HALF = 17,
    parameter int NBW  = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start,
    input  logic [NBW-1:0] nbytes,
    input  logic [7:0]     tx_byte,
    output logic [NBW-1:0] tx_idx,
    input  logic           miso,
    output logic           sck,
    output logic           cs_n,
    output logic           mosi,
    output logic           rx_vld,
    output logic [7:0]     rx_byte,
    output logic [NBW-1:0] rx_idx,
    output logic           fdone
);
    localparam int FULL = 2 * HALF;
    localparam int DW   = $clog2(FULL + 1);

    typedef struct packed {
        eng_st_e        st;
        logic [DW-1:0]  div;
        logic [2:0]     bitc;
        logic [NBW-1:0] bytec;
        logic [NBW-1:0] nb;
        logic [7:0]     txsh;
        logic [7:0]     rxsh;
        logic [NBW-1:0] rxi;
        logic           sck;
        logic           csn;
        logic           rxv;
        logic           fdone;
    } eng_s;

    eng_s q, d;

    always_comb begin
        d       = q;
        d.rxv   = 1'b0;
        d.fdone = 1'b0;
        tx_idx  = (q.st == E_IDLE) ? '0 : q.bytec + NBW'(1);
        case (q.st)
            E_IDLE: if (start) begin
                d.st    = E_SETUP;
                d.csn   = 1'b0;
                d.div   = '0;
                d.bitc  = '0;
                d.bytec = '0;
                d.nb    = nbytes;
                d.txsh  = tx_byte;
            end
            E_SETUP, E_LO: begin
                if (q.div == DW'((q.st == E_SETUP) ? FULL - 1 : HALF - 1)) begin
                    d.st   = E_HI;
                    d.sck  = 1'b1;
                    d.div  = '0;
                    d.rxsh = {q.rxsh[6:0], miso};
                end else begin
                    d.div = q.div + DW'(1);
                end
            end
            E_HI: begin
                if (q.div == DW'(HALF - 1)) begin
                    d.sck = 1'b0;
                    d.div = '0;
                    d.st  = E_LO;
                    if (q.bitc == 3'd7) begin
                        d.rxv = 1'b1;
                        d.rxi = q.bytec;
                        if (q.bytec == q.nb - NBW'(1)) begin
                            d.st = E_HOLD;
                        end else begin
                            d.bytec = q.bytec + NBW'(1);
                            d.bitc  = '0;
                            d.txsh  = tx_byte;
                        end
                    end else begin
                        d.bitc = q.bitc + 3'd1;
                        d.txsh = {q.txsh[6:0], 1'b0};
                    end
                end else begin
                    d.div = q.div + DW'(1);
                end
            end
            E_HOLD, E_GAP: begin
                if (q.div == DW'(FULL - 1)) begin
                    d.div = '0;
                    if (q.st == E_HOLD) begin
                        d.csn = 1'b1;
                        d.st  = E_GAP;
                    end else begin
                        d.st    = E_IDLE;
                        d.fdone = 1'b1;
                    end
                end else begin
                    d.div = q.div + DW'(1);
                end
            end
            default: d.st = E_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q     <= '0;
            q.csn <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign sck     = q.sck;
    assign cs_n    = q.csn;
    assign mosi    = q.txsh[7];
    assign rx_vld  = q.rxv;
    assign rx_byte = q.rxsh;
    assign rx_idx  = q.rxi;
    assign fdone   = q.fdone;
endmodule

// File: rtl/spi_txn_ctrl.sv
`timescale 1ns/1ps
module spi_txn_ctrl
    import spi_eeprom_pkg::*;
#(
    parameter int MAXB    = 8,
    parameter int POLLS   = 10,
    parameter int GAP_CYC = 50000,
    parameter int LW      = $clog2(MAXB + 1),
    parameter int NBW     = $clog2(MAXB + 3)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [1:0]        req_op,
    input  logic [7:0]        req_addr,
    input  logic [LW-1:0]     req_len,
    input  logic [8*MAXB-1:0] req_wdata,
    input  logic              req_bad,
    output logic              req_ready,
    output logic              done,
    output logic [1:0]        result,
    output logic [8*MAXB-1:0] rdata,
    output logic              eng_start,
    output logic [NBW-1:0]    eng_nbytes,
    input  logic [NBW-1:0]    eng_tx_idx,
    output logic [7:0]        eng_tx_byte,
    input  logic              eng_rx_vld,
    input  logic [7:0]        eng_rx_byte,
    input  logic [NBW-1:0]    eng_rx_idx,
    input  logic              eng_fdone
);
    localparam int PW = $clog2(POLLS + 1);
    localparam int GW = $clog2(GAP_CYC + 1);

    typedef struct packed {
        ctl_st_e           st;
        frm_e              frm;
        logic [7:0]        addr;
        logic [LW-1:0]     len;
        logic [8*MAXB-1:0] wdata;
        logic [7:0]        stat;
        logic [PW-1:0]     polls;
        logic [GW-1:0]     gap;
        logic              done;
        res_e              res;
        logic [8*MAXB-1:0] rdata;
    } ctl_s;

    ctl_s q, d;

    always_comb begin
        d         = q;
        d.done    = 1'b0;
        eng_start = 1'b0;
        case (q.st)
            C_IDLE: if (req_valid) begin
                d.addr  = req_addr;
                d.len   = req_len;
                d.wdata = req_wdata;
                d.rdata = '0;
                if (req_bad) begin
                    d.done = 1'b1;
                    d.res  = RES_INVAL;
                end else begin
                    d.st  = C_LAUNCH;
                    d.frm = (op_e'(req_op) == OP_WRITE) ? F_WREN :
                            (op_e'(req_op) == OP_READ)  ? F_READ : F_WRDI;
                end
            end
            C_LAUNCH: begin
                eng_start = 1'b1;
                d.st      = C_WAIT;
            end
            C_WAIT: begin
                if (eng_rx_vld) begin
                    if ((q.frm == F_CHK || q.frm == F_POLL) && eng_rx_idx == NBW'(1))
                        d.stat = eng_rx_byte;
                    if (q.frm == F_READ)
                        for (int i = 0; i < MAXB; i++)
                            if (eng_rx_idx == NBW'(i + 2)) d.rdata[8*i +: 8] = eng_rx_byte;
                end
                if (eng_fdone) begin
                    d.st = C_IDLE;
                    case (q.frm)
                        F_WREN: begin
                            d.frm = F_CHK;
                            d.st  = C_LAUNCH;
                        end
                        F_CHK: begin
                            if (q.stat[ST_WEN]) begin
                                d.frm = F_WRITE;
                                d.st  = C_LAUNCH;
                            end else begin
                                d.done = 1'b1;
                                d.res  = RES_PERM;
                            end
                        end
                        F_WRITE: begin
                            d.frm   = F_POLL;
                            d.polls = '0;
                            d.st    = C_LAUNCH;
                        end
                        F_POLL: begin
                            if (!q.stat[ST_BUSY]) begin
                                d.done = 1'b1;
                                d.res  = RES_OK;
                            end else if (q.polls == PW'(POLLS - 1)) begin
                                d.done = 1'b1;
                                d.res  = RES_IO;
                            end else begin
                                d.polls = q.polls + PW'(1);
                                d.gap   = '0;
                                d.st    = C_DELAY;
                            end
                        end
                        default: begin
                            d.done = 1'b1;
                            d.res  = RES_OK;
                        end
                    endcase
                end
            end
            C_DELAY: begin
                if (q.gap == GW'(GAP_CYC - 1)) d.st = C_LAUNCH;
                else                          d.gap = q.gap + GW'(1);
            end
            default: d.st = C_IDLE;
        endcase
    end

    always_comb begin
        eng_nbytes  = NBW'(1);
        eng_tx_byte = 8'h00;
        case (q.frm)
            F_WREN: eng_tx_byte = CMD_WREN;
            F_WRDI: eng_tx_byte = CMD_WRDI;
            F_CHK, F_POLL: begin
                eng_nbytes = NBW'(2);
                if (eng_tx_idx == '0) eng_tx_byte = CMD_RDSR;
            end
            F_WRITE, F_READ: begin
                eng_nbytes = NBW'(q.len) + NBW'(2);
                if (eng_tx_idx == '0)
                    eng_tx_byte = (q.frm == F_WRITE) ? CMD_PROG : CMD_READ;
                else if (eng_tx_idx == NBW'(1))
                    eng_tx_byte = q.addr;
                else if (q.frm == F_WRITE)
                    for (int i = 0; i < MAXB; i++)
                        if (eng_tx_idx == NBW'(i + 2)) eng_tx_byte = q.wdata[8*i +: 8];
            end
            default: eng_tx_byte = 8'h00;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign req_ready = (q.st == C_IDLE);
    assign done      = q.done;
    assign result    = q.res;
    assign rdata     = q.rdata;
endmodule

// File: rtl/spi_eeprom_seq.sv
`timescale 1ns/1ps
module spi_eeprom_seq
    import spi_eeprom_pkg::*;
#(
    parameter int CLK_HZ = 50_000_000,
    parameter int SCK_HZ = 1_500_000,
    parameter int GAP_US = 1000,
    parameter int POLLS  = 10,
    parameter int MAXB   = 8,
    parameter int PAGE   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [1:0]        req_op,
    input  logic [7:0]        req_addr,
    input  logic [3:0]        req_len,
    input  logic [8*MAXB-1:0] req_wdata,
    output logic              req_ready,
    output logic              done,
    output logic [1:0]        result,
    output logic [8*MAXB-1:0] rdata,
    output logic              sck,
    output logic              cs_n,
    output logic              mosi,
    input  logic              miso
);
    localparam int HALF    = (CLK_HZ + 2 * SCK_HZ - 1) / (2 * SCK_HZ);
    localparam int GAP_CYC = (CLK_HZ / 1_000_000) * GAP_US;
    localparam int LW      = 4;
    localparam int NBW     = $clog2(MAXB + 3);

    logic           req_bad;
    logic           eng_start, eng_rx_vld, eng_fdone;
    logic [NBW-1:0] eng_nbytes, eng_tx_idx, eng_rx_idx;
    logic [7:0]     eng_tx_byte, eng_rx_byte;

    eeprom_req_check #(.MAXB(MAXB), .PAGE(PAGE), .LW(LW)) u_check (
        .op(req_op), .addr(req_addr), .len(req_len), .bad(req_bad)
    );

    spi_txn_ctrl #(.MAXB(MAXB), .POLLS(POLLS), .GAP_CYC(GAP_CYC), .LW(LW), .NBW(NBW)) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_op(req_op), .req_addr(req_addr), .req_len(req_len),
        .req_wdata(req_wdata), .req_bad(req_bad), .req_ready(req_ready),
        .done(done), .result(result), .rdata(rdata),
        .eng_start(eng_start), .eng_nbytes(eng_nbytes), .eng_tx_idx(eng_tx_idx),
        .eng_tx_byte(eng_tx_byte), .eng_rx_vld(eng_rx_vld), .eng_rx_byte(eng_rx_byte),
        .eng_rx_idx(eng_rx_idx), .eng_fdone(eng_fdone)
    );

    spi_frame_engine #(.HALF(HALF), .NBW(NBW)) u_engine (
        .clk(clk), .rst_n(rst_n), .start(eng_start), .nbytes(eng_nbytes),
        .tx_byte(eng_tx_byte), .tx_idx(eng_tx_idx), .miso(miso),
        .sck(sck), .cs_n(cs_n), .mosi(mosi),
        .rx_vld(eng_rx_vld), .rx_byte(eng_rx_byte), .rx_idx(eng_rx_idx), .fdone(eng_fdone)
    );
endmodule

// File: rtl/spi_eeprom_seq_chk.sv
`timescale 1ns/1ps
module spi_eeprom_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       req_valid,
    input logic [3:0] req_len,
    input logic       req_ready,
    input logic       done,
    input logic [1:0] result,
    input logic       sck,
    input logic       cs_n,
    input logic       mosi
);
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R2
    AST_DONE_WITH_READY: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> req_ready); // R2
    AST_IDLE_NO_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> cs_n); // R1
    AST_ZERO_LEN_INVAL: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && req_len == 4'd0) |=> (done && result == 2'd1)); // R3
    AST_SCK_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> !sck); // R10
    AST_MOSI_STEADY_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        sck |-> $stable(mosi)); // R10
    AST_CS_RISE_CLK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cs_n) |-> (!sck && !$past(sck))); // R11
endmodule

bind spi_eeprom_seq spi_eeprom_seq_chk u_chk (.*);

// File: tb/spi_eeprom_seq_bench.sv
`timescale 1ns/1ps
module spi_eeprom_seq_bench;
    localparam int    GAP_US  = 2;
    localparam int    CYC_NS  = 20;
    localparam int    HALF_EX = (50_000_000 + 3_000_000 - 1) / 3_000_000;
    localparam real   HALF_NS = HALF_EX * 20.0;

    logic clk = 1'b0, rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic [1:0] req_op = '0;
    logic [7:0] req_addr = '0;
    logic [3:0] req_len = '0;
    logic [63:0] req_wdata = '0;
    logic req_ready, done, sck, cs_n, mosi;
    logic miso = 1'b0;
    logic [1:0] result;
    logic [63:0] rdata;

    int nchk = 0, nfail = 0, done_cnt = 0;

    always #10 clk = ~clk;

    spi_eeprom_seq #(.GAP_US(GAP_US)) u_spi_eeprom_seq (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_addr(req_addr), .req_len(req_len), .req_wdata(req_wdata),
        .req_ready(req_ready), .done(done), .result(result), .rdata(rdata),
        .sck(sck), .cs_n(cs_n), .mosi(mosi), .miso(miso)
    );

    always @(negedge clk) if (done) done_cnt++;

    // ---------------- device model ----------------
    logic [7:0] mem [256];
    logic [7:0] flog [64][12];
    int   flen [64];
    real  gap_before [64];
    int   fcount = 0, byte_i = 0, bc = 0, busy_left = 0, busy_cfg = 0;
    bit   model_on = 0, wel = 0, block_wel = 0, first_rise = 0, seen_rise = 0;
    logic [7:0] rxb = 0, txb = 0;
    real  t_csfall = 0, t_csrise = 0, t_fall = 0, t_rise = 0;
    real  min_setup = 1e9, min_hold = 1e9, min_high = 1e9;
    real  min_sck_hi = 1e9, max_sck_hi = 0;

    function automatic logic [7:0] status_byte();
        return {6'b0, wel && !block_wel, busy_left != 0};
    endfunction

    always @(negedge cs_n) if (model_on) begin
        byte_i = 0; bc = 0; txb = 8'h00; miso = 1'b0;
        t_csfall = $realtime; first_rise = 1;
        if (seen_rise) begin
            if ($realtime - t_csrise < min_high) min_high = $realtime - t_csrise;
            if (fcount < 64) gap_before[fcount] = $realtime - t_csrise;
        end
    end

    always @(posedge sck) if (model_on && !cs_n) begin
        logic [7:0] nb;
        t_rise = $realtime;
        if (first_rise && ($realtime - t_csfall < min_setup)) min_setup = $realtime - t_csfall;
        first_rise = 0;
        nb = {rxb[6:0], mosi};
        rxb = nb;
        if (bc == 7) begin
            if (fcount < 64 && byte_i < 12) flog[fcount][byte_i] = nb;
            byte_i++;
            bc = 0;
            txb = 8'h00;
            if (fcount < 64) begin
                if (flog[fcount][0] == 8'h05 && byte_i == 1) txb = status_byte();
                if (flog[fcount][0] == 8'h03 && byte_i >= 2)
                    txb = mem[8'(flog[fcount][1] + 8'(byte_i - 2))];
            end
        end else begin
            bc++;
        end
    end

    always @(negedge sck) if (model_on && !cs_n) begin
        real hi;
        hi = $realtime - t_rise;
        if (hi < min_sck_hi) min_sck_hi = hi;
        if (hi > max_sck_hi) max_sck_hi = hi;
        t_fall = $realtime;
        miso = txb[7 - bc];
    end

    always @(posedge cs_n) if (model_on) begin
        if (byte_i > 0 && ($realtime - t_fall < min_hold)) min_hold = $realtime - t_fall;
        t_csrise = $realtime; seen_rise = 1;
        if (fcount < 64) begin
            flen[fcount] = byte_i;
            case (flog[fcount][0])
                8'h06: wel = 1;
                8'h04: wel = 0;
                8'h05: if (busy_left > 0) busy_left--;
                8'h02: if (byte_i > 2 && wel) begin
                    for (int k = 2; k < byte_i; k++)
                        mem[8'(flog[fcount][1] + 8'(k - 2))] = flog[fcount][k];
                    busy_left = busy_cfg;
                    wel = 0;
                end
                default: ;
            endcase
            fcount++;
        end
    end

    // ---------------- helpers ----------------
    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic clear_log();
        fcount = 0; busy_left = 0; wel = 0; block_wel = 0; busy_cfg = 0;
    endtask

    task automatic run_req(input logic [1:0] op, input logic [7:0] a, input logic [3:0] n,
                           input logic [63:0] wd, output logic [1:0] res,
                           output logic [63:0] rd, output int lat);
        int k;
        @(negedge clk);
        req_valid = 1'b1; req_op = op; req_addr = a; req_len = n; req_wdata = wd;
        @(negedge clk);
        req_valid = 1'b0;
        k = 1;
        while (!done && k < 100000) begin
            @(negedge clk);
            k++;
        end
        res = result; rd = rdata; lat = k;
        repeat (5) @(negedge clk);
    endtask

    task automatic chk_frame(input int f, input int n, input logic [7:0] b0, input string tag);
        check(flen[f] == n, {tag, " frame length"}, flen[f], n);
        check(flog[f][0] == b0, {tag, " frame opcode"}, flog[f][0], b0);
    endtask

    // ---------------- scenarios ----------------
    task automatic t_reset();
        check(cs_n == 1'b1, "R12 cs_n after reset", cs_n, 1);
        check(sck == 1'b0, "R12 sck after reset", sck, 0);
        check(req_ready == 1'b1, "R12 ready after reset", req_ready, 1);
        check(done == 1'b0, "R12 done after reset", done, 0);
    endtask

    task automatic t_wrdis();
        logic [1:0] r; logic [63:0] rd; int lat, d0;
        clear_log(); d0 = done_cnt;
        run_req(2'd2, 8'h00, 4'd1, '0, r, rd, lat);
        check(r == 2'd0, "R9 write-disable result", r, 0);
        check(fcount == 1, "R9 frame count", fcount, 1);
        chk_frame(0, 1, 8'h04, "R9");
        check(done_cnt - d0 == 1, "R2 single done pulse", done_cnt - d0, 1);
    endtask

    task automatic t_read_busy_ignore();
        logic [1:0] r; logic [63:0] exp; int k, d0;
        clear_log(); d0 = done_cnt;
        exp = {40'h0, mem[8'h12], mem[8'h11], mem[8'h10]};
        @(negedge clk);
        req_valid = 1'b1; req_op = 2'd0; req_addr = 8'h10; req_len = 4'd3; req_wdata = '0;
        @(negedge clk);
        req_valid = 1'b0;
        repeat (300) @(negedge clk);
        check(req_ready == 1'b0, "R1 ready low while busy", req_ready, 0);
        req_valid = 1'b1; req_op = 2'd2;
        @(negedge clk);
        req_valid = 1'b0;
        k = 0;
        while (!done && k < 100000) begin @(negedge clk); k++; end
        r = result;
        check(r == 2'd0, "R8 read result", r, 0);
        check(rdata == exp, "R8 read data", rdata, exp);
        repeat (600) @(negedge clk);
        check(fcount == 1, "R1 request while busy ignored", fcount, 1);
        check(done_cnt - d0 == 1, "R1 one completion only", done_cnt - d0, 1);
        chk_frame(0, 5, 8'h03, "R8");
        check(flog[0][1] == 8'h10, "R8 address byte", flog[0][1], 8'h10);
    endtask

    task automatic t_write_ok();
        logic [1:0] r; logic [63:0] rd, wd; int lat;
        clear_log(); busy_cfg = 2;
        wd = 64'h8877_6655_4433_2211;
        run_req(2'd1, 8'h20, 4'd8, wd, r, rd, lat);
        check(r == 2'd0, "R7 write result ok", r, 0);
        check(fcount == 6, "R7 frame count with two busy polls", fcount, 6);
        chk_frame(0, 1, 8'h06, "R4 enable");
        chk_frame(1, 2, 8'h05, "R4 status");
        check(flog[1][1] == 8'h00, "R4 status dummy byte", flog[1][1], 0);
        chk_frame(2, 10, 8'h02, "R6 program");
        check(flog[2][1] == 8'h20, "R6 address byte", flog[2][1], 8'h20);
        for (int i = 0; i < 8; i++)
            check(flog[2][i+2] == wd[8*i +: 8], "R6 data byte order", flog[2][i+2], wd[8*i +: 8]);
        chk_frame(5, 2, 8'h05, "R7 last poll");
        check(gap_before[4] >= GAP_US * 1000.0, "R13 poll gap",
              longint'(gap_before[4]), GAP_US * 1000);
        check(gap_before[5] >= GAP_US * 1000.0, "R13 poll gap second",
              longint'(gap_before[5]), GAP_US * 1000);
        clear_log();
        run_req(2'd0, 8'h20, 4'd8, '0, r, rd, lat);
        check(rd == wd, "R8 read back written page", rd, wd);
    endtask

    task automatic t_write_short();
        logic [1:0] r; logic [63:0] rd; int lat;
        clear_log(); busy_cfg = 0;
        run_req(2'd1, 8'h2D, 4'd3, 64'h0000_0000_00CC_BBAA, r, rd, lat);
        check(r == 2'd0, "R7 ready on first poll", r, 0);
        check(fcount == 4, "R7 single poll frame count", fcount, 4);
        chk_frame(2, 5, 8'h02, "R6 short program");
        check(flog[2][4] == 8'hCC, "R6 last data byte", flog[2][4], 8'hCC);
    endtask

    task automatic t_write_perm();
        logic [1:0] r; logic [63:0] rd; int lat;
        clear_log(); block_wel = 1;
        run_req(2'd1, 8'h40, 4'd2, 64'h1234, r, rd, lat);
        check(r == 2'd2, "R5 not-enabled result", r, 2);
        check(fcount == 2, "R5 no frame after status", fcount, 2);
    endtask

    task automatic t_write_io();
        logic [1:0] r; logic [63:0] rd; int lat;
        clear_log(); busy_cfg = 50;
        run_req(2'd1, 8'h48, 4'd1, 64'h77, r, rd, lat);
        check(r == 2'd3, "R7 busy timeout result", r, 3);
        check(fcount == 13, "R7 poll limit frame count", fcount, 13);
        chk_frame(12, 2, 8'h05, "R7 final poll");
    endtask

    task automatic t_invalid();
        logic [1:0] r; logic [63:0] rd; int lat;
        clear_log();
        run_req(2'd1, 8'h06, 4'd3, 64'h1, r, rd, lat);
        check(r == 2'd1, "R3 page crossing invalid", r, 1);
        check(lat == 1, "R3 invalid done next cycle", lat, 1);
        run_req(2'd0, 8'h00, 4'd0, 64'h0, r, rd, lat);
        check(r == 2'd1, "R3 zero length invalid", r, 1);
        run_req(2'd1, 8'h00, 4'd9, 64'h0, r, rd, lat);
        check(r == 2'd1, "R3 length nine invalid", r, 1);
        run_req(2'd3, 8'h00, 4'd1, 64'h0, r, rd, lat);
        check(r == 2'd1, "R3 reserved op invalid", r, 1);
        check(fcount == 0, "R3 no bus traffic", fcount, 0);
    endtask

    task automatic t_timing();
        check(min_sck_hi == HALF_NS && max_sck_hi == HALF_NS, "R10 sck high phase",
              longint'(min_sck_hi), longint'(HALF_NS));
        check(min_setup >= 2.0 * HALF_NS, "R11 cs setup", longint'(min_setup), longint'(2.0 * HALF_NS));
        check(min_hold >= 2.0 * HALF_NS, "R11 cs hold", longint'(min_hold), longint'(2.0 * HALF_NS));
        check(min_high >= 2.0 * HALF_NS, "R11 cs high", longint'(min_high), longint'(2.0 * HALF_NS));
    endtask

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 8'(i) ^ 8'hA5;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        model_on = 1;
        t_reset();
        t_wrdis();
        t_read_busy_ignore();
        t_write_ok();
        t_write_short();
        t_write_perm();
        t_write_io();
        t_invalid();
        t_timing();
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        nchk++; nfail++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end
endmodule